// File: doc/BRIEF.md
# Variable-length bit accumulation buffer

The block gathers a stream of data chunks, each carrying between 0 and 64 meaningful bits, into one wide staging register so that a later computation can work on the whole register at once. On every accepted beat the low `in_len` bits of the 64-bit word are placed directly after the bits already held, and a fill pointer moves forward by the number of bits stored. Bit 0 of the register is the first position filled.

Gathering ends when the register is full or when the producer marks a beat as the last one of its message. The block then presents the register to the consumer with `blk_valid` and refuses further input. After the consumer pulses `blk_done` the register and pointer are cleared and intake resumes. A chunk that runs past the top of the register is cut: only the bits that fit are kept, and the count of dropped bits is shown on `spill_cnt`.

The input side is a valid/ready stream. A beat transfers only on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low in the cycle after reset and for as long as a full or finished block waits for the consumer. A producer must hold its beat steady until it sees `in_ready`. The output side has no back-pressure: `blk_valid` stays high until `blk_done`.

Top module: `chunk_packer`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `blk_valid` and `in_ready` are 0, `blk_fill` is 0 and `blk_data` is all zeros. `in_ready` becomes 1 one clock edge after reset is released.
- R2: An accepted beat writes its stored bits into `blk_data` starting at bit index `blk_fill`, in order: input bit 0 goes to index `blk_fill`. Bits already held are kept.
- R3: Input bits at positions `in_len` and above never reach `blk_data`, whatever their value.
- R4: `blk_fill` advances by the number of bits stored. An accepted beat with `in_len` = 0 leaves `blk_data` and `blk_fill` unchanged.
- R5: Any `in_len` value above 64 is treated as 64.
- R6: When a beat does not fit, only the bits up to the top index are stored. `blk_fill` becomes the register width, and `spill_cnt` shows the number of offered bits that were dropped. `blk_valid` rises on the same edge. `spill_cnt` is 0 after any beat that fits.
- R7: An accepted beat with `in_last` = 1 raises `blk_valid` on the accepting edge, even if the register is not full.
- R8: While `blk_valid` is 1, `in_ready` is 0 and offered beats change neither `blk_data` nor `blk_fill`.
- R9: `blk_done` while `blk_valid` is 1 clears `blk_data`, `blk_fill`, `spill_cnt` and `blk_valid` on the next edge, and `in_ready` returns to 1 at that edge.
- R10: In a cycle with no transfer and no `blk_done`, `blk_data` and `blk_fill` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a beat |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | WORD_W (64) | Chunk bits, bit 0 is stored first |
| in_len | input | LEN_W (7) | Count of valid bits in `in_data`; values above WORD_W are treated as WORD_W |
| in_last | input | 1 | Beat is the last one of the message |
| blk_valid | output | 1 | Register is complete and held for the consumer |
| blk_done | input | 1 | One-cycle pulse from the consumer: block consumed |
| blk_data | output | BUF_W (1024) | Staging register |
| blk_fill | output | FILL_W (11) | Number of bits currently held (0 to BUF_W) |
| spill_cnt | output | LEN_W (7) | Bits of the last accepted beat that did not fit |

## Verification
Every result is registered, so each one is due one clock edge after its cause. This covers the merged bits, the new fill count, `spill_cnt`, the rise of `blk_valid` and the clear after `blk_done`. `in_ready` is a decode of the state, so it follows the same edge. The bench changes inputs on the falling edge and withdraws `in_valid` right after the accepting edge. It then reads outputs on the next falling edge, so every check looks at the state exactly one edge after its stimulus and never at an edge itself. The bench computes expected register contents from its own bit-by-bit model of the requirements. It uses a 256-bit register so that an overflow is reached in a few beats.

// File: rtl/chunk_packer_pkg.sv
package chunk_packer_pkg;

  typedef enum logic [1:0] {
    PK_IDLE   = 2'd0,
    PK_GATHER = 2'd1,
    PK_HOLD   = 2'd2
  } pk_state_e;

endpackage

// File: rtl/cp_take_calc.sv
// Works out how many offered bits fit and how many spill.
module cp_take_calc #(
  parameter int WORD_W = 64,
  parameter int BUF_W  = 1024,
  localparam int LEN_W  = $clog2(WORD_W + 1),
  localparam int FILL_W = $clog2(BUF_W + 1)
) (
  input  logic [LEN_W-1:0]  len_raw,
  input  logic [FILL_W-1:0] fill,
  output logic [LEN_W-1:0]  take,
  output logic [LEN_W-1:0]  spill,
  output logic [FILL_W-1:0] fill_next,
  output logic              hits_top
);
  localparam logic [LEN_W-1:0]  WORD_MAX = LEN_W'(WORD_W);
  localparam logic [FILL_W-1:0] TOP      = FILL_W'(BUF_W);

  logic [LEN_W-1:0]  len_c;
  logic [FILL_W-1:0] room;

  always_comb begin
    len_c = (len_raw > WORD_MAX) ? WORD_MAX : len_raw;
    room  = TOP - fill;
    if (FILL_W'(len_c) <= room) take = len_c;
    else                        take = LEN_W'(room);
    spill     = len_c - take;
    fill_next = fill + FILL_W'(take);
    hits_top  = (fill_next == TOP);
  end
endmodule

// File: rtl/cp_merge.sv
// Masks the word to the kept length and shifts it to the fill offset.
module cp_merge #(
  parameter int WORD_W = 64,
  parameter int BUF_W  = 1024,
  localparam int LEN_W  = $clog2(WORD_W + 1),
  localparam int FILL_W = $clog2(BUF_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  take,
  input  logic [FILL_W-1:0] fill,
  output logic [BUF_W-1:0]  placed
);
  logic [WORD_W-1:0] keep_mask;
  logic [WORD_W-1:0] kept;
  logic [BUF_W-1:0]  widened;

  for (genvar g = 0; g < WORD_W; g++) begin : g_mask
    assign keep_mask[g] = (take > LEN_W'(g));
  end

  assign kept    = word & keep_mask;
  assign widened = {{(BUF_W - WORD_W){1'b0}}, kept};
  assign placed  = widened << fill;
endmodule

// File: rtl/cp_ctrl.sv
// Intake state machine, fill pointer and spill register.
module cp_ctrl #(
  parameter int WORD_W = 64,
  parameter int BUF_W  = 1024,
  localparam int LEN_W  = $clog2(WORD_W + 1),
  localparam int FILL_W = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              blk_done,
  input  logic [LEN_W-1:0]  spill_now,
  input  logic [FILL_W-1:0] fill_next,
  input  logic              hits_top,
  output logic              accept,
  output logic              clear,
  output logic              in_ready,
  output logic              blk_valid,
  output logic [FILL_W-1:0] fill,
  output logic [LEN_W-1:0]  spill_cnt
);
  import chunk_packer_pkg::*;

  pk_state_e state, state_n;

  assign in_ready  = (state == PK_GATHER);
  assign blk_valid = (state == PK_HOLD);
  assign accept    = in_valid && in_ready;
  assign clear     = blk_valid && blk_done;

  always_comb begin
    state_n = state;
    unique case (state)
      PK_IDLE:   state_n = PK_GATHER;
      PK_GATHER: if (accept && (hits_top || in_last)) state_n = PK_HOLD;
      PK_HOLD:   if (blk_done) state_n = PK_GATHER;
      default:   state_n = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PK_IDLE;
      fill      <= '0;
      spill_cnt <= '0;
    end else begin
      state <= state_n;
      if (clear) begin
        fill      <= '0;
        spill_cnt <= '0;
      end else if (accept) begin
        fill      <= fill_next;
        spill_cnt <= spill_now;
      end
    end
  end
endmodule

// File: rtl/chunk_packer.sv
module chunk_packer #(
  parameter int WORD_W = 64,
  parameter int BUF_W  = 1024,
  localparam int LEN_W  = $clog2(WORD_W + 1),
  localparam int FILL_W = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_last,
  output logic              blk_valid,
  input  logic              blk_done,
  output logic [BUF_W-1:0]  blk_data,
  output logic [FILL_W-1:0] blk_fill,
  output logic [LEN_W-1:0]  spill_cnt
);
  logic [LEN_W-1:0]  take, spill_now;
  logic [FILL_W-1:0] fill_next;
  logic              hits_top, accept, clear;
  logic [BUF_W-1:0]  placed;

  cp_take_calc #(.WORD_W(WORD_W), .BUF_W(BUF_W)) u_take (
    .len_raw(in_len), .fill(blk_fill), .take(take), .spill(spill_now),
    .fill_next(fill_next), .hits_top(hits_top)
  );

  cp_merge #(.WORD_W(WORD_W), .BUF_W(BUF_W)) u_merge (
    .word(in_data), .take(take), .fill(blk_fill), .placed(placed)
  );

  cp_ctrl #(.WORD_W(WORD_W), .BUF_W(BUF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .blk_done(blk_done), .spill_now(spill_now), .fill_next(fill_next),
    .hits_top(hits_top), .accept(accept), .clear(clear),
    .in_ready(in_ready), .blk_valid(blk_valid), .fill(blk_fill),
    .spill_cnt(spill_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_data <= '0;
    else if (clear)  blk_data <= '0;
    else if (accept) blk_data <= blk_data | placed;
  end
endmodule

// File: rtl/chunk_packer_checker.sv
module chunk_packer_checker #(
  parameter int WORD_W = 64,
  parameter int BUF_W  = 1024,
  localparam int LEN_W  = $clog2(WORD_W + 1),
  localparam int FILL_W = $clog2(BUF_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LEN_W-1:0]  in_len,
  input logic              blk_valid,
  input logic              blk_done,
  input logic [BUF_W-1:0]  blk_data,
  input logic [FILL_W-1:0] blk_fill,
  input logic [LEN_W-1:0]  spill_cnt
);
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !in_ready); // R8
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    blk_fill <= FILL_W'(BUF_W)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_fill == FILL_W'(BUF_W)) |-> blk_valid); // R6
  AST_SPILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_cnt != '0) |-> blk_valid); // R6
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_len == '0) |=> $stable(blk_fill) && $stable(blk_data)); // R4
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !blk_done) |=> $stable(blk_fill) && $stable(blk_data)); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_done) |=> (blk_fill == '0) && !blk_valid && in_ready); // R9
endmodule

bind chunk_packer chunk_packer_checker #(.WORD_W(WORD_W), .BUF_W(BUF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_len(in_len), .blk_valid(blk_valid), .blk_done(blk_done),
  .blk_data(blk_data), .blk_fill(blk_fill), .spill_cnt(spill_cnt)
);

// File: tb/chunk_packer_bench.sv
`timescale 1ns/1ps
module chunk_packer_bench;
  localparam int WORD_W = 64;
  localparam int BUF_W  = 256;
  localparam int LEN_W  = $clog2(WORD_W + 1);
  localparam int FILL_W = $clog2(BUF_W + 1);
  localparam int NV     = 7;

  localparam logic [63:0] TD [0:NV-1] = '{
    64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_CAFE_F00D,
    64'hA5A5_5A5A_0FF0_F00F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1357_9BDF_2468_ACE0,
    64'hFFFF_FFFF_FFFF_FFFF };
  localparam int TL [0:NV-1] = '{8, 0, 64, 100, 37, 64, 40};
  localparam int TF [0:NV-1] = '{8, 8, 72, 136, 173, 237, 256};
  localparam int TS [0:NV-1] = '{0, 0, 0, 0, 0, 0, 21};
  localparam int TV [0:NV-1] = '{0, 0, 0, 0, 0, 0, 1};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_last, blk_done;
  logic              in_ready, blk_valid;
  logic [WORD_W-1:0] in_data;
  logic [LEN_W-1:0]  in_len;
  logic [BUF_W-1:0]  blk_data;
  logic [FILL_W-1:0] blk_fill;
  logic [LEN_W-1:0]  spill_cnt;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [BUF_W-1:0] mdl;
  int mfill;

  always #2 clk = ~clk;

  chunk_packer #(.WORD_W(WORD_W), .BUF_W(BUF_W)) u_chunk_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .in_last(in_last),
    .blk_valid(blk_valid), .blk_done(blk_done), .blk_data(blk_data),
    .blk_fill(blk_fill), .spill_cnt(spill_cnt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_buf(input string req);
    n_chk++;
    if (blk_data !== mdl) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, blk_data, mdl);
    end
  endtask

  // bench model of an accepted beat, from R2 R3 R5 R6
  task automatic model_beat(input logic [63:0] d, input int len);
    int cl, take;
    cl   = (len > WORD_W) ? WORD_W : len;
    take = (cl < BUF_W - mfill) ? cl : BUF_W - mfill;
    for (int b = 0; b < take; b++) mdl[mfill + b] = d[b];
    mfill += take;
  endtask

  task automatic beat(input logic [63:0] d, input int len, input logic last);
    in_valid = 1'b1; in_data = d; in_len = LEN_W'(len); in_last = last;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; blk_done = 1'b0;
    in_data = '0; in_len = '0; mdl = '0; mfill = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 valid", blk_valid, 0);
    chk("R1 ready", in_ready, 0);
    chk("R1 fill", blk_fill, 0);
    chk_buf("R1 data");
    rst_n = 1'b1;
    chk("R1 ready first cycle", in_ready, 0);
    @(negedge clk);
    chk("R1 ready after edge", in_ready, 1);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      model_beat(TD[i], TL[i]);
      beat(TD[i], TL[i], 1'b0);
      chk($sformatf("R4 fill step %0d", i), blk_fill, TF[i]);
      chk($sformatf("R6 spill step %0d", i), spill_cnt, TS[i]);
      chk($sformatf("R6 valid step %0d", i), blk_valid, TV[i]);
      chk_buf($sformatf("R2 R3 R5 data step %0d", i));
    end

    // R8: beats refused while block is held
    chk("R8 ready low", in_ready, 0);
    beat(64'hFFFF_FFFF_FFFF_FFFF, 64, 1'b0);
    chk("R8 fill kept", blk_fill, BUF_W);
    chk_buf("R8 data kept");

    // R9: consume clears
    blk_done = 1'b1;
    @(posedge clk); @(negedge clk);
    blk_done = 1'b0;
    mdl = '0; mfill = 0;
    chk("R9 fill", blk_fill, 0);
    chk("R9 spill", spill_cnt, 0);
    chk("R9 valid", blk_valid, 0);
    chk("R9 ready", in_ready, 1);
    chk_buf("R9 data");

    // R10: idle cycles with garbage on the bus
    in_data = 64'hFFFF_FFFF_FFFF_FFFF; in_len = LEN_W'(64);
    repeat (3) @(negedge clk);
    chk("R10 fill", blk_fill, 0);
    chk_buf("R10 data");

    // R7: short last beat closes the block
    model_beat(64'h0000_0000_0000_00F5, 5);
    beat(64'h0000_0000_0000_00F5, 5, 1'b1);
    chk("R7 valid", blk_valid, 1);
    chk("R7 fill", blk_fill, 5);
    chk_buf("R7 data R3 mask");

    blk_done = 1'b1;
    @(posedge clk); @(negedge clk);
    blk_done = 1'b0;
    chk("R9 second clear", blk_fill, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule